// File: doc/BRIEF.md
# Scalar Immediate-Operand ALU

This block is the execute stage for a class of scalar instructions in which each operation combines one 32-bit scalar register value with a 16-bit immediate. A decoder upstream supplies the opcode, a selector that chooses between two opcode maps, the current destination value, the immediate and the current scalar condition bit. One cycle later the block presents the new destination value with a write enable, the new condition bit with a separate write enable, and a flag for opcodes that are not defined in the selected map.

Sixteen operations are supported: load of the immediate, load of the immediate gated by the condition bit, six signed and six unsigned relational tests, a signed add with overflow detection and a signed multiply. Each opcode decides how the immediate is extended and whether the result goes to the register, to the condition bit, or to both. Both opcode maps are first converted to one internal operation code, so a single datapath serves both.

Top module: `scalar_imm_alu`

## Requirements
- R1: While rst_n is low, every output is 0.
- R2: With map_sel=1 the codes are: 0 load, 1 gated load, 2..7 signed equal/not-equal/greater/greater-or-equal/less/less-or-equal, 8..13 the same six relations unsigned, 14 add, 15 multiply.
- R3: With map_sel=0, code 0 is load and every other operation sits one code higher than under map_sel=1 (gated load 2, signed equal 3 through unsigned less-or-equal 14, add 15, multiply 16).
- R4: An opcode with no operation in the selected map (code 1 and codes 17..31 under map_sel=0; codes 16..31 under map_sel=1) raises illegal and leaves dst_we and scc_we low.
- R5: Load writes the sign-extended immediate to the destination and leaves scc_we low.
- R6: Gated load writes the sign-extended immediate only when scc_in is 1; when scc_in is 0 dst_we stays low. It never writes the condition bit.
- R7: Signed relational tests compare the destination with the sign-extended immediate as 32-bit signed numbers, set scc_out to 1 when the relation holds and 0 otherwise, raise scc_we and keep dst_we low.
- R8: Unsigned relational tests compare the destination with the zero-extended immediate as unsigned numbers, with the same write behaviour as R7.
- R9: Add writes the low 32 bits of destination plus sign-extended immediate, raises both write enables, and sets scc_out to 1 exactly when the true sum is above 2^31-1 or below -2^31.
- R10: Multiply writes the low 32 bits of the signed product of destination and sign-extended immediate, with scc_we low.
- R11: Results appear on the outputs on the clock edge after the one that samples in_valid=1; after an edge that samples in_valid=0, dst_we, scc_we and illegal are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| map_sel | input | 1 | 1 selects the newer opcode map, 0 the older |
| opcode | input | 5 | Operation code in the selected map |
| dst_in | input | 32 | Current destination register value |
| imm | input | 16 | Immediate operand |
| scc_in | input | 1 | Current condition bit |
| dst_out | output | 32 | New destination value |
| dst_we | output | 1 | Destination write enable |
| scc_out | output | 1 | New condition bit |
| scc_we | output | 1 | Condition bit write enable |
| illegal | output | 1 | Opcode undefined in the selected map |

## Verification
The assertions watch every cycle for the write-enable pattern each operation class must produce: no writes beside an illegal flag, condition-only writes for relational tests, register-only writes for load and multiply, both writes for add, no register write for a gated load with the condition clear, and silence after an idle cycle. The values themselves, meaning the extension of the immediate, the signed and unsigned orderings, the overflow edges of the add and the wrapped product, and the exact placement of each code in the two maps, are shown only by the bench's vectors with their independently worked expected results.

// File: rtl/sia_pkg.sv
package sia_pkg;
  localparam int KIND_W  = 4;
  localparam int NUM_OPS = 16;

  // Internal operation code; values match the newer opcode map.
  typedef enum logic [KIND_W-1:0] {
    K_LOAD  = 4'd0,
    K_GLOAD = 4'd1,
    K_SEQ   = 4'd2,
    K_SNE   = 4'd3,
    K_SGT   = 4'd4,
    K_SGE   = 4'd5,
    K_SLT   = 4'd6,
    K_SLE   = 4'd7,
    K_UEQ   = 4'd8,
    K_UNE   = 4'd9,
    K_UGT   = 4'd10,
    K_UGE   = 4'd11,
    K_ULT   = 4'd12,
    K_ULE   = 4'd13,
    K_ADD   = 4'd14,
    K_MUL   = 4'd15
  } op_kind_e;

  localparam logic [KIND_W-1:0] FIRST_SIGNED_REL   = 4'd2;
  localparam logic [KIND_W-1:0] FIRST_UNSIGNED_REL = 4'd8;
endpackage

// File: rtl/sia_decode.sv
module sia_decode
  import sia_pkg::*;
#(
  parameter int OP_W = 5
) (
  input  logic            map_new,
  input  logic [OP_W-1:0] opcode,
  output op_kind_e        kind_o,
  output logic            legal_o
);
  localparam int LEGACY_TOP = NUM_OPS;  // highest code in the older map

  logic [OP_W-1:0] idx;

  always_comb begin
    idx     = '0;
    legal_o = 1'b0;
    if (map_new) begin
      legal_o = (int'(opcode) < NUM_OPS);
      idx     = opcode;
    end else if (opcode == '0) begin
      legal_o = 1'b1;
      idx     = '0;
    end else begin
      legal_o = (int'(opcode) >= 2) && (int'(opcode) <= LEGACY_TOP);
      idx     = opcode - OP_W'(1);
    end
    if (!legal_o) idx = '0;
    kind_o = op_kind_e'(idx[KIND_W-1:0]);
  end
endmodule

// File: rtl/sia_exec.sv
module sia_exec
  import sia_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  op_kind_e          kind,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic              scc_val,
  output logic [DATA_W-1:0] res_dst,
  output logic              res_dwe,
  output logic              res_scc,
  output logic              res_swe
);
  localparam int EXT_W = DATA_W - IMM_W;

  function automatic logic rel_holds(input logic [2:0] rel, input logic sgn,
                                     input logic [DATA_W-1:0] a,
                                     input logic [DATA_W-1:0] b);
    logic eq;
    logic lt;
    eq = (a == b);
    lt = sgn ? ($signed(a) < $signed(b)) : (a < b);
    case (rel)
      3'd0:    return eq;
      3'd1:    return !eq;
      3'd2:    return !lt && !eq;
      3'd3:    return !lt;
      3'd4:    return lt;
      default: return lt || eq;
    endcase
  endfunction

  // Returns {overflow, low sum}: one extra bit is enough to see the range break.
  function automatic logic [DATA_W:0] add_ovf(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
    logic [DATA_W:0] wide;
    wide = {a[DATA_W-1], a} + {b[DATA_W-1], b};
    return {wide[DATA_W] ^ wide[DATA_W-1], wide[DATA_W-1:0]};
  endfunction

  function automatic logic [DATA_W-1:0] mul_lo(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
    logic signed [2*DATA_W-1:0] prod;
    prod = $signed({{DATA_W{a[DATA_W-1]}}, a}) * $signed({{DATA_W{b[DATA_W-1]}}, b});
    return prod[DATA_W-1:0];
  endfunction

  logic [DATA_W-1:0] imm_sx;
  logic [DATA_W-1:0] imm_zx;
  logic [DATA_W:0]   sum_w;
  logic              is_signed_rel;
  logic [KIND_W-1:0] rel_base;
  logic [KIND_W-1:0] rel_off;

  assign imm_sx        = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign imm_zx        = {{EXT_W{1'b0}}, imm};
  assign sum_w         = add_ovf(dst_val, imm_sx);
  assign is_signed_rel = (kind < op_kind_e'(FIRST_UNSIGNED_REL));
  assign rel_base      = is_signed_rel ? FIRST_SIGNED_REL : FIRST_UNSIGNED_REL;
  assign rel_off       = kind - rel_base;

  always_comb begin
    res_dst = dst_val;
    res_dwe = 1'b0;
    res_scc = scc_val;
    res_swe = 1'b0;
    unique case (kind)
      K_LOAD: begin
        res_dst = imm_sx;
        res_dwe = 1'b1;
      end
      K_GLOAD: begin
        res_dst = imm_sx;
        res_dwe = scc_val;
      end
      K_ADD: begin
        res_dst = sum_w[DATA_W-1:0];
        res_dwe = 1'b1;
        res_scc = sum_w[DATA_W];
        res_swe = 1'b1;
      end
      K_MUL: begin
        res_dst = mul_lo(dst_val, imm_sx);
        res_dwe = 1'b1;
      end
      default: begin
        res_scc = rel_holds(rel_off[2:0], is_signed_rel, dst_val,
                            is_signed_rel ? imm_sx : imm_zx);
        res_swe = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/scalar_imm_alu.sv
module scalar_imm_alu
  import sia_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int OP_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              map_sel,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] dst_in,
  input  logic [IMM_W-1:0]  imm,
  input  logic              scc_in,
  output logic [DATA_W-1:0] dst_out,
  output logic              dst_we,
  output logic              scc_out,
  output logic              scc_we,
  output logic              illegal
);
  op_kind_e          dec_kind;
  logic              dec_legal;
  logic [DATA_W-1:0] ex_dst;
  logic              ex_dwe;
  logic              ex_scc;
  logic              ex_swe;
  logic              issue_ok;
  logic              issue_bad;

  sia_decode #(.OP_W(OP_W)) u_dec (
    .map_new (map_sel),
    .opcode  (opcode),
    .kind_o  (dec_kind),
    .legal_o (dec_legal)
  );

  sia_exec #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_exec (
    .kind    (dec_kind),
    .dst_val (dst_in),
    .imm     (imm),
    .scc_val (scc_in),
    .res_dst (ex_dst),
    .res_dwe (ex_dwe),
    .res_scc (ex_scc),
    .res_swe (ex_swe)
  );

  assign issue_ok  = in_valid && dec_legal;
  assign issue_bad = in_valid && !dec_legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_out <= '0;
      dst_we  <= 1'b0;
      scc_out <= 1'b0;
      scc_we  <= 1'b0;
      illegal <= 1'b0;
    end else begin
      dst_out <= ex_dst;
      scc_out <= ex_scc;
      dst_we  <= issue_ok && ex_dwe;
      scc_we  <= issue_ok && ex_swe;
      illegal <= issue_bad;
    end
  end
endmodule

// File: rtl/sia_chk.sv
module sia_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       scc_in,
  input logic       dec_legal,
  input logic [3:0] dec_kind,
  input logic       dst_we,
  input logic       scc_we,
  input logic       illegal
);
  logic go;
  logic k_rel;
  assign go    = in_valid && dec_legal;
  assign k_rel = (dec_kind >= 4'd2) && (dec_kind <= 4'd13);

  assert_illegal_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!dst_we && !scc_we));

  assert_rel_scc_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && k_rel) |=> (scc_we && !dst_we && !illegal));

  assert_gload_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && dec_kind == 4'd1 && !scc_in) |=> (!dst_we && !scc_we));

  assert_load_keep_scc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && dec_kind == 4'd0) |=> (dst_we && !scc_we));

  assert_mul_keep_scc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (go && dec_kind == 4'd15) |=> (dst_we && !scc_we));

  assert_add_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && dec_kind == 4'd14) |=> (dst_we && scc_we));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!dst_we && !scc_we && !illegal));
endmodule

bind scalar_imm_alu sia_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .scc_in    (scc_in),
  .dec_legal (dec_legal),
  .dec_kind  (dec_kind),
  .dst_we    (dst_we),
  .scc_we    (scc_we),
  .illegal   (illegal)
);

// File: tb/tb_scalar_imm_alu.sv
`timescale 1ns/1ps
module tb_scalar_imm_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        map_sel = 1'b1;
  logic [4:0]  opcode = '0;
  logic [31:0] dst_in = '0;
  logic [15:0] imm = '0;
  logic        scc_in = 1'b0;
  logic [31:0] dst_out;
  logic        dst_we, scc_out, scc_we, illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scalar_imm_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .map_sel(map_sel),
    .opcode(opcode), .dst_in(dst_in), .imm(imm), .scc_in(scc_in),
    .dst_out(dst_out), .dst_we(dst_we), .scc_out(scc_out), .scc_we(scc_we),
    .illegal(illegal)
  );

  // {req, map, op, dst, imm, scc | ill, dwe, edst, swe, escc}
  localparam int NV = 27;
  localparam logic [94:0] VEC [NV] = '{
    {4'd5,  1'b1, 5'd0,  32'h0000_0000, 16'h8001, 1'b0, 1'b0, 1'b1, 32'hFFFF_8001, 1'b0, 1'b0}, // R5 R2
    {4'd6,  1'b1, 5'd1,  32'h0000_0005, 16'h1234, 1'b1, 1'b0, 1'b1, 32'h0000_1234, 1'b0, 1'b0}, // R6
    {4'd6,  1'b1, 5'd1,  32'h0000_0005, 16'h1234, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R6
    {4'd7,  1'b1, 5'd2,  32'hFFFF_FFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b1}, // R7
    {4'd7,  1'b1, 5'd4,  32'h0000_0000, 16'hFFFF, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b1}, // R7
    {4'd7,  1'b1, 5'd6,  32'h8000_0000, 16'h0001, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b1}, // R7
    {4'd7,  1'b1, 5'd5,  32'hFFFF_FFFE, 16'hFFFF, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0}, // R7
    {4'd7,  1'b1, 5'd7,  32'h7FFF_FFFF, 16'h8000, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0}, // R7
    {4'd7,  1'b1, 5'd3,  32'h0000_0009, 16'h0009, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0}, // R7
    {4'd8,  1'b1, 5'd8,  32'hFFFF_FFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0}, // R8
    {4'd8,  1'b1, 5'd10, 32'h0001_0000, 16'hFFFF, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b1}, // R8
    {4'd8,  1'b1, 5'd13, 32'h0000_FFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b1}, // R8
    {4'd8,  1'b1, 5'd9,  32'h0000_0003, 16'h0003, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0}, // R8
    {4'd8,  1'b1, 5'd12, 32'h0000_0004, 16'h8000, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b1}, // R8
    {4'd9,  1'b1, 5'd14, 32'h7FFF_FFFF, 16'h0001, 1'b0, 1'b0, 1'b1, 32'h8000_0000, 1'b1, 1'b1}, // R9
    {4'd9,  1'b1, 5'd14, 32'h8000_0000, 16'hFFFF, 1'b0, 1'b0, 1'b1, 32'h7FFF_FFFF, 1'b1, 1'b1}, // R9
    {4'd9,  1'b1, 5'd14, 32'h0000_0010, 16'hFFFF, 1'b1, 1'b0, 1'b1, 32'h0000_000F, 1'b1, 1'b0}, // R9
    {4'd10, 1'b1, 5'd15, 32'h0001_0000, 16'h0003, 1'b1, 1'b0, 1'b1, 32'h0003_0000, 1'b0, 1'b0}, // R10
    {4'd10, 1'b1, 5'd15, 32'h1234_5678, 16'hFFFF, 1'b0, 1'b0, 1'b1, 32'hEDCB_A988, 1'b0, 1'b0}, // R10
    {4'd10, 1'b1, 5'd15, 32'h0001_0000, 16'h8000, 1'b0, 1'b0, 1'b1, 32'h8000_0000, 1'b0, 1'b0}, // R10
    {4'd3,  1'b0, 5'd0,  32'h0000_0000, 16'h0007, 1'b0, 1'b0, 1'b1, 32'h0000_0007, 1'b0, 1'b0}, // R3
    {4'd3,  1'b0, 5'd2,  32'h0000_0000, 16'h00AA, 1'b1, 1'b0, 1'b1, 32'h0000_00AA, 1'b0, 1'b0}, // R3
    {4'd3,  1'b0, 5'd3,  32'h0000_0005, 16'h0005, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b1}, // R3
    {4'd3,  1'b0, 5'd15, 32'h0000_0001, 16'h0001, 1'b1, 1'b0, 1'b1, 32'h0000_0002, 1'b1, 1'b0}, // R3
    {4'd3,  1'b0, 5'd16, 32'h0000_0003, 16'hFFFE, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFA, 1'b0, 1'b0}, // R3
    {4'd4,  1'b0, 5'd1,  32'h0000_0003, 16'h0001, 1'b1, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R4
    {4'd4,  1'b1, 5'd16, 32'h0000_0003, 16'h0001, 1'b1, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0}  // R4
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic quiet(input string req, input string what);
    chk(!dst_we && !scc_we && !illegal, req, what,
        {29'd0, dst_we, scc_we, illegal}, 32'd0);
  endtask

  task automatic issue(input logic m, input logic [4:0] op, input logic [31:0] d,
                       input logic [15:0] i, input logic s);
    @(negedge clk);
    in_valid = 1'b1; map_sel = m; opcode = op; dst_in = d; imm = i; scc_in = s;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    chk(1'b0, "WDOG", "watchdog expired", 32'd0, 32'd1);
    done = 1'b1;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    chk(dst_out == 32'd0 && !dst_we && !scc_out && !scc_we && !illegal, "R1",
        "reset state", dst_out, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [94:0] e;
      string rq;
      e = VEC[v];
      rq = $sformatf("R%0d vec%0d", e[94:91], v);
      issue(e[90], e[89:85], e[84:53], e[52:37], e[36]);
      chk(illegal == e[35], rq, "illegal", {31'd0, illegal}, {31'd0, e[35]});
      chk(dst_we == e[34], rq, "dst_we", {31'd0, dst_we}, {31'd0, e[34]});
      if (e[34]) chk(dst_out == e[33:2], rq, "dst_out", dst_out, e[33:2]);
      chk(scc_we == e[1], rq, "scc_we", {31'd0, scc_we}, {31'd0, e[1]});
      if (e[1]) chk(scc_out == e[0], rq, "scc_out", {31'd0, scc_out}, {31'd0, e[0]});
    end

    // R11: idle cycle after an operation leaves all enables low
    issue(1'b1, 5'd14, 32'd1, 16'd1, 1'b0);
    chk(dst_we && scc_we, "R11", "one-cycle latency", {30'd0, dst_we, scc_we}, 32'd3);
    @(negedge clk);
    quiet("R11", "idle after op");

    // R4: highest code of each map beyond range
    issue(1'b0, 5'd31, 32'd0, 16'd0, 1'b1);
    chk(illegal && !dst_we && !scc_we, "R4", "old map code 31",
        {29'd0, illegal, dst_we, scc_we}, 32'd4);
    issue(1'b0, 5'd17, 32'd0, 16'd0, 1'b1);
    chk(illegal && !dst_we && !scc_we, "R4", "old map code 17",
        {29'd0, illegal, dst_we, scc_we}, 32'd4);

    // R2: code 15 new map is multiply, while code 15 old map is add
    issue(1'b1, 5'd15, 32'd7, 16'd7, 1'b0);
    chk(dst_we && !scc_we && dst_out == 32'd49, "R2", "new map code 15 multiply", dst_out, 32'd49);

    // R1: reset asserted mid-run clears outputs
    issue(1'b1, 5'd0, 32'd0, 16'h00FF, 1'b0);
    rst_n = 1'b0;
    #1;
    chk(dst_out == 32'd0 && !dst_we && !scc_we && !illegal && !scc_out, "R1",
        "async reset clears", dst_out, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule